// File: doc/BRIEF.md
# Write-Only Serial Control Register Slave

This block is the control-port front end of an audio processing core. It listens on a two-wire I2C bus in standard mode as a slave that can only be written. An external master sends a device address, a one-byte subaddress that selects a control register, and then that register's payload. The block collects the payload bytes and copies them into the parallel register outputs only after the master ends the transfer. Each register output has its own single-cycle update strobe, which tells the downstream datapath that new settings are present.

Each subaddress has a fixed payload length. A write is committed only when the STOP condition arrives and exactly that many bytes have been received. A shorter write leaves the register untouched. The upper five bits of the device address are fixed. Two select pins supply the two lowest bits, so up to four of these blocks can share one bus. While the core's internal initialization runs, the slave acknowledges nothing.

SCL and SDA are sampled by the system clock through two-flop synchronizers. The system clock must run at least 16 times faster than SCL. SDA is driven open-drain: the block only outputs a pull-down request.

Top module: `i2c_wr_regs`

## Requirements
- R1: The slave acknowledges an address byte only if its upper seven bits equal binary 01101 followed by `sel_a1` and then `sel_a0`. Any other address is not acknowledged, and no register or strobe changes for that transfer.
- R2: An address byte whose least significant bit (R/W) is 1 is not acknowledged, and the transfer changes nothing.
- R3: The slave acknowledges by asserting `sda_pull` from the SCL falling edge after a byte's eighth bit until the SCL falling edge after the ninth bit. It starts driving only while SCL is low. At all other times `sda_pull` is low, including after STOP.
- R4: The accepted subaddresses and their payload lengths are 0x01 → `ctl_q` (1 byte), 0x04 → `vol_q` (6 bytes) and 0x07 → `mix_q` (3 bytes). Any other subaddress is not acknowledged, and nothing is updated.
- R5: After reset, `ctl_q` = 0x80 (only the top bit set), `vol_q` = 0, `mix_q` = 0x100000, all strobes are low and `sda_pull` is low.
- R6: On STOP after a complete payload, the addressed register takes the payload. The first data byte lands in the most significant byte. The register holds its value at all other times.
- R7: A write that ends with fewer data bytes than its subaddress's payload length (including zero bytes) changes no register and raises no strobe.
- R8: Data bytes beyond the payload length are not acknowledged and not stored. The payload already received is still committed at STOP.
- R9: While `init_busy` is high when the address byte completes, the address is not acknowledged and the transfer changes nothing.
- R10: A repeated START discards any partly received payload, and a new transfer begins with an address byte.
- R11: Each commit pulses the strobe of the written register, and only that strobe, high for exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire |
| sda_pull | output | 1 | 1 = pull SDA low (open-drain enable) |
| sel_a1 | input | 1 | Device address bit 1 |
| sel_a0 | input | 1 | Device address bit 0 |
| init_busy | input | 1 | High while core initialization runs; blocks acknowledges |
| ctl_q | output | 8 | Mode register, subaddress 0x01 |
| ctl_upd | output | 1 | One-cycle pulse when `ctl_q` is written |
| vol_q | output | 48 | Volume register, subaddress 0x04 |
| vol_upd | output | 1 | One-cycle pulse when `vol_q` is written |
| mix_q | output | 24 | Mixer gain register, subaddress 0x07 |
| mix_upd | output | 1 | One-cycle pulse when `mix_q` is written |

## Verification
A wrong bit counter or a wrong protocol state shows up within one byte as a missing or misplaced acknowledge on SDA. The bench therefore samples the acknowledge of every byte in the middle of the ninth SCL high phase. A wrong byte count or a stale staging buffer stays hidden until the next STOP. At that point it appears as a register value that differs from the expected one, or as a strobe that fires when none should (or stays silent). Registers and strobe counts are compared a few cycles after every STOP, against a model built from the requirements.

// File: rtl/i2c_wr_regs.sv
module i2c_wr_regs #(
  parameter logic [4:0] ADDR_HI   = 5'b01101,
  parameter logic [7:0] SUB_CTL   = 8'h01,
  parameter logic [7:0] SUB_VOL   = 8'h04,
  parameter logic [7:0] SUB_MIX   = 8'h07,
  parameter int         CTL_BYTES = 1,
  parameter int         VOL_BYTES = 6,
  parameter int         MIX_BYTES = 3,
  parameter logic [8*CTL_BYTES-1:0] CTL_RST = 'h80,
  parameter logic [8*MIX_BYTES-1:0] MIX_RST = 'h100000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_pull,
  input  logic                   sel_a1,
  input  logic                   sel_a0,
  input  logic                   init_busy,
  output logic [8*CTL_BYTES-1:0] ctl_q,
  output logic                   ctl_upd,
  output logic [8*VOL_BYTES-1:0] vol_q,
  output logic                   vol_upd,
  output logic [8*MIX_BYTES-1:0] mix_q,
  output logic                   mix_upd
);
  localparam int CTL_W = 8 * CTL_BYTES;
  localparam int VOL_W = 8 * VOL_BYTES;
  localparam int MIX_W = 8 * MIX_BYTES;
  localparam int STG_BYTES = (VOL_BYTES > MIX_BYTES) ?
                             ((VOL_BYTES > CTL_BYTES) ? VOL_BYTES : CTL_BYTES) :
                             ((MIX_BYTES > CTL_BYTES) ? MIX_BYTES : CTL_BYTES);
  localparam int STG_W = 8 * STG_BYTES;
  localparam int CW = $clog2(STG_BYTES + 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_SUB, S_DATA, S_SKIP} phase_t;

  function automatic logic [CW-1:0] plen(input logic [7:0] s);
    if (s == SUB_CTL)      return CW'(CTL_BYTES);
    else if (s == SUB_VOL) return CW'(VOL_BYTES);
    else if (s == SUB_MIX) return CW'(MIX_BYTES);
    else                   return '0;
  endfunction

  logic [1:0]       scl_sy, sda_sy;
  logic             scl_d, sda_d;
  phase_t           st;
  logic [3:0]       bitn;
  logic             in_ack, ack_o;
  logic [7:0]       sh, sub_q;
  logic [CW-1:0]    cnt;
  logic [STG_W-1:0] stg;

  wire scl_s = scl_sy[1];
  wire sda_s = sda_sy[1];
  wire rise  = scl_s & ~scl_d;
  wire fall  = ~scl_s & scl_d;
  wire start = scl_s & scl_d & sda_d & ~sda_s;
  wire stop  = scl_s & scl_d & ~sda_d & sda_s;
  wire live  = (st != S_IDLE) && (st != S_SKIP);
  wire [7:0] my_addr = {ADDR_HI, sel_a1, sel_a0, 1'b0};

  assign sda_pull = ack_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_sy  <= 2'b11;
      sda_sy  <= 2'b11;
      scl_d   <= 1'b1;
      sda_d   <= 1'b1;
      st      <= S_IDLE;
      bitn    <= '0;
      in_ack  <= 1'b0;
      ack_o   <= 1'b0;
      sh      <= '0;
      sub_q   <= '0;
      cnt     <= '0;
      stg     <= '0;
      ctl_q   <= CTL_RST;
      vol_q   <= '0;
      mix_q   <= MIX_RST;
      ctl_upd <= 1'b0;
      vol_upd <= 1'b0;
      mix_upd <= 1'b0;
    end else begin
      scl_sy  <= {scl_sy[0], scl_i};
      sda_sy  <= {sda_sy[0], sda_i};
      scl_d   <= scl_s;
      sda_d   <= sda_s;
      ctl_upd <= 1'b0;
      vol_upd <= 1'b0;
      mix_upd <= 1'b0;
      if (start) begin
        st     <= S_ADDR;
        bitn   <= '0;
        in_ack <= 1'b0;
        ack_o  <= 1'b0;
        cnt    <= '0;
      end else if (stop) begin
        if (st == S_DATA && cnt == plen(sub_q)) begin
          if (sub_q == SUB_CTL) begin
            ctl_q   <= stg[CTL_W-1:0];
            ctl_upd <= 1'b1;
          end else if (sub_q == SUB_VOL) begin
            vol_q   <= stg[VOL_W-1:0];
            vol_upd <= 1'b1;
          end else begin
            mix_q   <= stg[MIX_W-1:0];
            mix_upd <= 1'b1;
          end
        end
        st     <= S_IDLE;
        in_ack <= 1'b0;
        ack_o  <= 1'b0;
      end else if (rise && live && !in_ack) begin
        sh   <= {sh[6:0], sda_s};
        bitn <= bitn + 4'd1;
      end else if (fall && in_ack) begin
        ack_o  <= 1'b0;
        in_ack <= 1'b0;
        bitn   <= '0;
      end else if (fall && live && bitn == 4'd8) begin
        in_ack <= 1'b1;
        case (st)
          S_ADDR:
            if (sh == my_addr && !init_busy) begin
              ack_o <= 1'b1;
              st    <= S_SUB;
            end else begin
              st    <= S_SKIP;
            end
          S_SUB: begin
            sub_q <= sh;
            cnt   <= '0;
            if (plen(sh) != '0) begin
              ack_o <= 1'b1;
              st    <= S_DATA;
            end else begin
              st    <= S_SKIP;
            end
          end
          S_DATA:
            if (cnt < plen(sub_q)) begin
              ack_o <= 1'b1;
              stg   <= {stg[STG_W-9:0], sh};
              cnt   <= cnt + CW'(1);
            end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_wr_regs_chk.sv
module i2c_wr_regs_chk #(
  parameter int CW_CTL = 8,
  parameter int CW_VOL = 48,
  parameter int CW_MIX = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_pull,
  input logic [CW_CTL-1:0] ctl_q,
  input logic              ctl_upd,
  input logic [CW_VOL-1:0] vol_q,
  input logic              vol_upd,
  input logic [CW_MIX-1:0] mix_q,
  input logic              mix_upd
);
  assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl_upd, vol_upd, mix_upd}));

  assert_ctl_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_upd |=> !ctl_upd);

  assert_vol_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    vol_upd |=> !vol_upd);

  assert_mix_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mix_upd |=> !mix_upd);

  assert_ctl_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_upd |-> $stable(ctl_q));

  assert_vol_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !vol_upd |-> $stable(vol_q));

  assert_mix_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mix_upd |-> $stable(mix_q));

  assert_drive_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_i);
endmodule

bind i2c_wr_regs i2c_wr_regs_chk #(
  .CW_CTL(CTL_W), .CW_VOL(VOL_W), .CW_MIX(MIX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_pull(sda_pull),
  .ctl_q(ctl_q), .ctl_upd(ctl_upd), .vol_q(vol_q), .vol_upd(vol_upd),
  .mix_q(mix_q), .mix_upd(mix_upd)
);

// File: tb/sim_i2c_wr_regs.sv
module sim_i2c_wr_regs;
  localparam int CLK_NS = 10;
  localparam int Q = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  logic m_scl = 1'b1, m_low = 1'b0;
  logic sel_a1 = 1'b0, sel_a0 = 1'b0, init_busy = 1'b0;
  logic sda_pull;
  logic [7:0]  ctl_q;
  logic [47:0] vol_q;
  logic [23:0] mix_q;
  logic ctl_upd, vol_upd, mix_upd;
  wire  sda_bus = ~(m_low | sda_pull);

  i2c_wr_regs u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_pull(sda_pull),
    .sel_a1(sel_a1), .sel_a0(sel_a0), .init_busy(init_busy),
    .ctl_q(ctl_q), .ctl_upd(ctl_upd), .vol_q(vol_q), .vol_upd(vol_upd),
    .mix_q(mix_q), .mix_upd(mix_upd)
  );

  int n_cmp = 0, n_bad = 0;
  int c_ctl = 0, c_vol = 0, c_mix = 0;
  int e_cctl = 0, e_cvol = 0, e_cmix = 0;
  logic [7:0]  ectl = 8'h80;
  logic [47:0] evol = '0;
  logic [23:0] emix = 24'h100000;

  always @(posedge clk) begin
    if (ctl_upd) c_ctl++;
    if (vol_upd) c_vol++;
    if (mix_upd) c_mix++;
  end

  function automatic int plen(input logic [7:0] s);
    case (s)
      8'h01: return 1;
      8'h04: return 6;
      8'h07: return 3;
      default: return 0;
    endcase
  endfunction

  function automatic logic [6:0] dev();
    return {5'b01101, sel_a1, sel_a0};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bstart();
    m_low = 1'b0; waitq(1);
    m_scl = 1'b1; waitq(1);
    m_low = 1'b1; waitq(1);
    m_scl = 1'b0; waitq(1);
  endtask

  task automatic bstop();
    m_low = 1'b1; waitq(1);
    m_scl = 1'b1; waitq(1);
    m_low = 1'b0; waitq(2);
  endtask

  task automatic bbyte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; waitq(1);
      m_scl = 1'b1;  waitq(2);
      m_scl = 1'b0;  waitq(1);
    end
    m_low = 1'b0; waitq(1);
    m_scl = 1'b1; waitq(1);
    ack = ~sda_bus;
    waitq(1);
    m_scl = 1'b0; waitq(1);
  endtask

  task automatic check_regs(input string tag);
    chk({tag, " R6 ctl_q"}, 64'(ctl_q), 64'(ectl));
    chk({tag, " R6 vol_q"}, 64'(vol_q), 64'(evol));
    chk({tag, " R6 mix_q"}, 64'(mix_q), 64'(emix));
    chk({tag, " R11 ctl strobes"}, 64'(c_ctl), 64'(e_cctl));
    chk({tag, " R11 vol strobes"}, 64'(c_vol), 64'(e_cvol));
    chk({tag, " R11 mix strobes"}, 64'(c_mix), 64'(e_cmix));
    chk({tag, " R3 released after stop"}, 64'(sda_pull), 64'd0);
  endtask

  task automatic xfer(input string tag, input logic [6:0] a, input bit rw,
                      input logic [7:0] sub, input int n, input logic [47:0] d,
                      input bit busy);
    bit ack, a_ok;
    int len;
    logic [47:0] v;
    len = plen(sub);
    init_busy = busy;
    bstart();
    bbyte({a, rw}, ack);
    a_ok = (a == dev()) && !rw && !busy;
    chk({tag, " R1 R2 R9 address ack"}, 64'(ack), 64'(a_ok));
    init_busy = 1'b0;
    if (ack) begin
      bbyte(sub, ack);
      chk({tag, " R4 subaddress ack"}, 64'(ack), 64'(len != 0));
      if (ack) begin
        for (int i = 0; i < n; i++) begin
          bbyte(d[47-8*i -: 8], ack);
          chk({tag, " R3 R8 data ack"}, 64'(ack), 64'(i < len));
        end
      end
    end
    bstop();
    if (a_ok && len != 0 && n >= len) begin
      v = '0;
      for (int i = 0; i < len; i++) v = {v[39:0], d[47-8*i -: 8]};
      if (len == 1)      begin ectl = v[7:0];  e_cctl++; end
      else if (len == 6) begin evol = v;       e_cvol++; end
      else               begin emix = v[23:0]; e_cmix++; end
    end
    check_regs(tag);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    bit ack;
    void'($urandom(32'd20240611));
    repeat (8) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk("R5 ctl reset", 64'(ctl_q), 64'h80);
    chk("R5 vol reset", 64'(vol_q), 64'h0);
    chk("R5 mix reset", 64'(mix_q), 64'h100000);
    chk("R5 strobes low", 64'({ctl_upd, vol_upd, mix_upd}), 64'h0);
    chk("R5 sda released", 64'(sda_pull), 64'h0);

    xfer("R6 full volume", dev(), 1'b0, 8'h04, 6, 48'h01_23_45_67_89_AB, 1'b0);
    xfer("R7 short volume", dev(), 1'b0, 8'h04, 5, 48'hFE_DC_BA_98_76_54, 1'b0);
    xfer("R7 zero bytes", dev(), 1'b0, 8'h07, 0, 48'h0, 1'b0);
    xfer("R6 ctl write", dev(), 1'b0, 8'h01, 1, 48'h5A_00_00_00_00_00, 1'b0);
    xfer("R6 mix write", dev(), 1'b0, 8'h07, 3, 48'h0A_BC_DE_00_00_00, 1'b0);
    xfer("R8 extra bytes", dev(), 1'b0, 8'h07, 5, 48'h11_22_33_44_55_00, 1'b0);
    xfer("R1 wrong address", 7'b0110111, 1'b0, 8'h01, 1, 48'h77_00_00_00_00_00, 1'b0);
    xfer("R2 read bit", dev(), 1'b1, 8'h01, 1, 48'h66_00_00_00_00_00, 1'b0);
    xfer("R4 unknown sub", dev(), 1'b0, 8'h02, 1, 48'h55_00_00_00_00_00, 1'b0);
    xfer("R9 busy", dev(), 1'b0, 8'h01, 1, 48'h44_00_00_00_00_00, 1'b1);

    // R10: repeated START after a partial volume payload
    bstart();
    bbyte({dev(), 1'b0}, ack);
    bbyte(8'h04, ack);
    for (int i = 0; i < 3; i++) bbyte(8'hC0 + 8'(i), ack);
    bstart();
    bbyte({dev(), 1'b0}, ack);
    chk("R10 address ack after restart", 64'(ack), 64'd1);
    bbyte(8'h01, ack);
    bbyte(8'h3C, ack);
    bstop();
    ectl = 8'h3C;
    e_cctl++;
    check_regs("R10 restart");

    sel_a1 = 1'b1;
    sel_a0 = 1'b0;
    xfer("R1 old address after select change", 7'b0110100, 1'b0, 8'h01, 1, 48'h99_00_00_00_00_00, 1'b0);
    xfer("R1 new address", dev(), 1'b0, 8'h01, 1, 48'hA5_00_00_00_00_00, 1'b0);

    for (int t = 0; t < 28; t++) begin
      logic [6:0] a;
      logic [7:0] sub;
      logic [47:0] d;
      int len, n, k;
      bit rw, busy;
      a = ($urandom % 5 == 0) ? 7'($urandom) : dev();
      rw = ($urandom % 10 == 0);
      busy = ($urandom % 8 == 0);
      k = $urandom % 4;
      sub = (k == 0) ? 8'h01 : (k == 1) ? 8'h04 : (k == 2) ? 8'h07 : 8'($urandom);
      len = plen(sub);
      n = $urandom % ((len == 0 ? 3 : len) + 2);
      d = {16'($urandom), 32'($urandom)};
      xfer("random", a, rw, sub, n, d, busy);
    end

    finish_run();
  end
endmodule